// File: doc/BRIEF.md
# Bus Address Remapper

This block sits in the path between one bus master and one bus slave and rewrites only the address. Every other request signal goes from master to slave unchanged: cycle, strobe, write enable, byte selects, write data, cycle-type and burst-type tags. Every response signal goes from slave to master unchanged: acknowledge, error and read data. Data is 32 bits wide and addresses are 32-bit byte addresses.

The rewrite is a combinational chain of two stages, and each stage can be switched off. The first stage relocates the address into a window: the result is a fixed base plus the incoming address modulo a power-of-two window size. The second stage holds a table of aligned power-of-two source regions. An address that falls in a source region moves to the destination region with the same index and keeps its offset. An address that falls in no source region is forwarded unchanged. All of these settings are fixed when the design is elaborated.

Top module: `wb_addr_remap`

## Requirements
- R1: cyc, stb, we, sel[3:0], write data[31:0], cti[2:0] and bte[1:0] reach the slave port equal to the master port values in the same cycle.
- R2: ack, err and read data[31:0] reach the master port equal to the slave port values in the same cycle.
- R3: With the window stage on and no regions, the slave address is ORIGIN_BASE + (master address mod ORIGIN_SIZE). With base 0x0001_0000 and size 0x1000_0000, inputs 0x0000_0004 and 0x1000_0004 both give 0x0001_0004.
- R4: An address inside source region i leaves as destination base i plus its offset inside the region. With source 0x0003_0000, destination 0x3000_0000 and size 0x1000, 0x0003_0fff gives 0x3000_0fff. The two lowest address bits are never altered.
- R5: A region whose source and destination bases are equal maps every address in it to itself.
- R6: With both stages on, the window stage runs first and its result feeds the region table. With window 0x1_0000/0x8_0000 and region 0x1_0000 (size 0x1_0000) mapped to 0x1000_0000, input 0x0 gives 0x1000_0000 and input 0x8_1234 gives 0x1000_1234.
- R7: An address that matches no source region after the window stage is forwarded unchanged. In the R6 setup, input 0x2_0000 gives 0x3_0000.
- R8: When several source regions contain the same address, the region with the lowest index is used.
- R9: No state and no latency: a new master address appears translated on the slave port in the same cycle, so addresses applied on consecutive cycles appear on consecutive cycles.
- R10: With the window stage off and zero regions, the slave address equals the master address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the bound checks (datapath is combinational) |
| rst_ni | input | 1 | Active-low asynchronous reset for the bound checks |
| m_cyc_i | input | 1 | Master cycle |
| m_stb_i | input | 1 | Master strobe |
| m_we_i | input | 1 | Master write enable |
| m_sel_i | input | 4 | Master byte selects |
| m_adr_i | input | 32 | Master byte address |
| m_dat_i | input | 32 | Master write data |
| m_cti_i | input | 3 | Master cycle-type tag |
| m_bte_i | input | 2 | Master burst-type tag |
| m_ack_o | output | 1 | Acknowledge to master |
| m_err_o | output | 1 | Error to master |
| m_dat_o | output | 32 | Read data to master |
| s_cyc_o | output | 1 | Slave cycle |
| s_stb_o | output | 1 | Slave strobe |
| s_we_o | output | 1 | Slave write enable |
| s_sel_o | output | 4 | Slave byte selects |
| s_adr_o | output | 32 | Translated slave byte address |
| s_dat_o | output | 32 | Slave write data |
| s_cti_o | output | 3 | Slave cycle-type tag |
| s_bte_o | output | 2 | Slave burst-type tag |
| s_ack_i | input | 1 | Acknowledge from slave |
| s_err_i | input | 1 | Error from slave |
| s_dat_i | input | 32 | Read data from slave |

## Verification
The window relocation and the region translation both act on the same address in the same cycle, so a fault in their order or their hand-off stays hidden unless one input passes through both. The bench provokes this with a combined instance. It applies inputs that the window stage folds into the source region, and one input that the window stage moves past the region. Each result is judged against a value worked out by hand from R6 and R7. The overlap case is provoked with two regions that contain the same address, and is judged by which destination appears.

// File: rtl/wb_remap_pkg.sv
package wb_remap_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned SW = DW / 8;

  typedef logic [AW-1:0] addr_t;

  typedef struct packed {
    logic          cyc;
    logic          stb;
    logic          we;
    logic [SW-1:0] sel;
    logic [DW-1:0] dat;
    logic [2:0]    cti;
    logic [1:0]    bte;
  } req_t;

  typedef struct packed {
    logic          ack;
    logic          err;
    logic [DW-1:0] dat;
  } rsp_t;

  // low-bit mask of a power-of-two size
  function automatic addr_t low_mask(addr_t size);
    return size - addr_t'(1);
  endfunction
endpackage

// File: rtl/wb_origin_stage.sv
module wb_origin_stage
  import wb_remap_pkg::*;
#(
  parameter bit    EN   = 1'b1,
  parameter addr_t BASE = 32'h0001_0000,
  parameter addr_t SIZE = 32'h1000_0000
) (
  input  addr_t adr_i,
  output addr_t adr_o
);
  generate
    if (EN) begin : g_on
      localparam addr_t MASK = low_mask(SIZE);
      assign adr_o = BASE + (adr_i & MASK);
    end else begin : g_off
      assign adr_o = adr_i;
    end
  endgenerate
endmodule

// File: rtl/wb_region_entry.sv
module wb_region_entry
  import wb_remap_pkg::*;
#(
  parameter addr_t SRC  = 32'h0000_0000,
  parameter addr_t DST  = 32'h0000_0000,
  parameter addr_t SIZE = 32'h0000_1000
) (
  input  addr_t adr_i,
  output logic  hit_o,
  output addr_t adr_o
);
  localparam addr_t MASK = low_mask(SIZE);
  localparam addr_t TAG  = SRC & ~MASK;
  localparam addr_t NEWT = DST & ~MASK;

  assign hit_o = (adr_i & ~MASK) == TAG;
  assign adr_o = NEWT | (adr_i & MASK);
endmodule

// File: rtl/wb_region_stage.sv
module wb_region_stage
  import wb_remap_pkg::*;
#(
  parameter int                      N_REGIONS    = 4,
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*AW-1:0] SRC_BASES    = '0,
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*AW-1:0] DST_BASES    = '0,
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*AW-1:0] REGION_SIZES = '0
) (
  input  addr_t adr_i,
  output addr_t adr_o
);
  generate
    if (N_REGIONS > 0) begin : g_tab
      logic  [N_REGIONS-1:0] hit;
      addr_t                 cand [N_REGIONS];

      for (genvar i = 0; i < N_REGIONS; i++) begin : g_ent
        wb_region_entry #(
          .SRC (SRC_BASES[i*AW +: AW]),
          .DST (DST_BASES[i*AW +: AW]),
          .SIZE(REGION_SIZES[i*AW +: AW])
        ) u_ent (
          .adr_i(adr_i),
          .hit_o(hit[i]),
          .adr_o(cand[i])
        );
      end

      // walk down so the lowest matching index lands last
      always_comb begin
        adr_o = adr_i;
        for (int i = N_REGIONS - 1; i >= 0; i--) begin
          if (hit[i]) adr_o = cand[i];
        end
      end
    end else begin : g_none
      assign adr_o = adr_i;
    end
  endgenerate
endmodule

// File: rtl/wb_addr_remap.sv
module wb_addr_remap
  import wb_remap_pkg::*;
#(
  parameter bit    ORIGIN_EN   = 1'b0,
  parameter addr_t ORIGIN_BASE = 32'h0000_0000,
  parameter addr_t ORIGIN_SIZE = 32'h1000_0000,
  parameter int    N_REGIONS   = 4,
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*32-1:0] SRC_BASES =
    {32'h0003_0000, 32'h0002_0000, 32'h0001_0000, 32'h0000_0000},
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*32-1:0] DST_BASES =
    {32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*32-1:0] REGION_SIZES =
    {32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'h0000_1000}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        m_cyc_i,
  input  logic        m_stb_i,
  input  logic        m_we_i,
  input  logic [3:0]  m_sel_i,
  input  logic [31:0] m_adr_i,
  input  logic [31:0] m_dat_i,
  input  logic [2:0]  m_cti_i,
  input  logic [1:0]  m_bte_i,
  output logic        m_ack_o,
  output logic        m_err_o,
  output logic [31:0] m_dat_o,
  output logic        s_cyc_o,
  output logic        s_stb_o,
  output logic        s_we_o,
  output logic [3:0]  s_sel_o,
  output logic [31:0] s_adr_o,
  output logic [31:0] s_dat_o,
  output logic [2:0]  s_cti_o,
  output logic [1:0]  s_bte_o,
  input  logic        s_ack_i,
  input  logic        s_err_i,
  input  logic [31:0] s_dat_i
);
  req_t  req;
  rsp_t  rsp;
  addr_t adr_mid;

  assign req = '{cyc: m_cyc_i, stb: m_stb_i, we: m_we_i, sel: m_sel_i,
                 dat: m_dat_i, cti: m_cti_i, bte: m_bte_i};
  assign {s_cyc_o, s_stb_o, s_we_o, s_sel_o, s_dat_o, s_cti_o, s_bte_o} = req;

  assign rsp = '{ack: s_ack_i, err: s_err_i, dat: s_dat_i};
  assign {m_ack_o, m_err_o, m_dat_o} = rsp;

  wb_origin_stage #(
    .EN  (ORIGIN_EN),
    .BASE(ORIGIN_BASE),
    .SIZE(ORIGIN_SIZE)
  ) u_org (
    .adr_i(m_adr_i),
    .adr_o(adr_mid)
  );

  wb_region_stage #(
    .N_REGIONS   (N_REGIONS),
    .SRC_BASES   (SRC_BASES),
    .DST_BASES   (DST_BASES),
    .REGION_SIZES(REGION_SIZES)
  ) u_reg (
    .adr_i(adr_mid),
    .adr_o(s_adr_o)
  );
endmodule

// File: rtl/wb_addr_remap_chk.sv
module wb_addr_remap_chk #(
  parameter bit          ORIGIN_EN   = 1'b0,
  parameter logic [31:0] ORIGIN_BASE = 32'h0,
  parameter logic [31:0] ORIGIN_SIZE = 32'h1000_0000,
  parameter int          N_REGIONS   = 4,
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*32-1:0] SRC_BASES    = '0,
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*32-1:0] DST_BASES    = '0,
  parameter logic [((N_REGIONS>0)?N_REGIONS:1)*32-1:0] REGION_SIZES = '0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] m_adr_i,
  input logic [31:0] s_adr_o
);
  // R4: byte lane bits untouched by any stage
  p_lane_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_adr_o[1:0] == m_adr_i[1:0]);

  // R9: no hidden state between master and slave address
  p_stateless_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(m_adr_i) |-> $stable(s_adr_o));

  generate
    if (ORIGIN_EN && N_REGIONS == 0) begin : g_win
      p_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_adr_o - ORIGIN_BASE) == (m_adr_i % ORIGIN_SIZE));
    end
    if (!ORIGIN_EN && N_REGIONS > 0) begin : g_tab
      logic        hit;
      logic [31:0] src_b, dst_b;
      always_comb begin
        logic [32:0] lo, hi;
        hit   = 1'b0;
        src_b = '0;
        dst_b = '0;
        for (int i = N_REGIONS - 1; i >= 0; i--) begin
          lo = {1'b0, SRC_BASES[i*32 +: 32]};
          hi = lo + {1'b0, REGION_SIZES[i*32 +: 32]};
          if ({1'b0, m_adr_i} >= lo && {1'b0, m_adr_i} < hi) begin
            hit   = 1'b1;
            src_b = SRC_BASES[i*32 +: 32];
            dst_b = DST_BASES[i*32 +: 32];
          end
        end
      end
      p_region_offset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |-> (s_adr_o - dst_b) == (m_adr_i - src_b));
      p_unmatched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit |-> s_adr_o == m_adr_i);
    end
    if (!ORIGIN_EN && N_REGIONS == 0) begin : g_thru
      p_identity_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_adr_o == m_adr_i);
    end
  endgenerate
endmodule

bind wb_addr_remap wb_addr_remap_chk #(
  .ORIGIN_EN   (ORIGIN_EN),
  .ORIGIN_BASE (ORIGIN_BASE),
  .ORIGIN_SIZE (ORIGIN_SIZE),
  .N_REGIONS   (N_REGIONS),
  .SRC_BASES   (SRC_BASES),
  .DST_BASES   (DST_BASES),
  .REGION_SIZES(REGION_SIZES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .m_adr_i(m_adr_i),
  .s_adr_o(s_adr_o)
);

// File: tb/sim_wb_addr_remap.sv
module sim_wb_addr_remap;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        cyc = 0, stb = 0, we = 0, s_ack = 0, s_err = 0;
  logic [3:0]  sel = 0;
  logic [31:0] adr = 0, wdat = 0, s_rdat = 0;
  logic [2:0]  cti = 0;
  logic [1:0]  bte = 0;

  logic        m_ack [4], m_err [4], o_cyc [4], o_stb [4], o_we [4];
  logic [31:0] m_rdat [4], o_adr [4], o_dat [4];
  logic [3:0]  o_sel [4];
  logic [2:0]  o_cti [4];
  logic [1:0]  o_bte [4];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // u0: window only
  wb_addr_remap #(.ORIGIN_EN(1'b1), .ORIGIN_BASE(32'h0001_0000),
    .ORIGIN_SIZE(32'h1000_0000), .N_REGIONS(0), .SRC_BASES('0),
    .DST_BASES('0), .REGION_SIZES('0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .m_cyc_i(cyc), .m_stb_i(stb), .m_we_i(we),
    .m_sel_i(sel), .m_adr_i(adr), .m_dat_i(wdat), .m_cti_i(cti), .m_bte_i(bte),
    .m_ack_o(m_ack[0]), .m_err_o(m_err[0]), .m_dat_o(m_rdat[0]),
    .s_cyc_o(o_cyc[0]), .s_stb_o(o_stb[0]), .s_we_o(o_we[0]), .s_sel_o(o_sel[0]),
    .s_adr_o(o_adr[0]), .s_dat_o(o_dat[0]), .s_cti_o(o_cti[0]), .s_bte_o(o_bte[0]),
    .s_ack_i(s_ack), .s_err_i(s_err), .s_dat_i(s_rdat));

  // u1: five regions, region 4 overlaps region 1
  wb_addr_remap #(.N_REGIONS(5),
    .SRC_BASES({32'h0001_0000, 32'h0003_0000, 32'h0002_0000, 32'h0001_0000, 32'h0000_0000}),
    .DST_BASES({32'h5000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000}),
    .REGION_SIZES({32'h100, 32'h1000, 32'h1000, 32'h1000, 32'h1000})) u1 (
    .clk_i(clk), .rst_ni(rst_n), .m_cyc_i(cyc), .m_stb_i(stb), .m_we_i(we),
    .m_sel_i(sel), .m_adr_i(adr), .m_dat_i(wdat), .m_cti_i(cti), .m_bte_i(bte),
    .m_ack_o(m_ack[1]), .m_err_o(m_err[1]), .m_dat_o(m_rdat[1]),
    .s_cyc_o(o_cyc[1]), .s_stb_o(o_stb[1]), .s_we_o(o_we[1]), .s_sel_o(o_sel[1]),
    .s_adr_o(o_adr[1]), .s_dat_o(o_dat[1]), .s_cti_o(o_cti[1]), .s_bte_o(o_bte[1]),
    .s_ack_i(s_ack), .s_err_i(s_err), .s_dat_i(s_rdat));

  // u2: window then one region
  wb_addr_remap #(.ORIGIN_EN(1'b1), .ORIGIN_BASE(32'h0001_0000),
    .ORIGIN_SIZE(32'h0008_0000), .N_REGIONS(1), .SRC_BASES(32'h0001_0000),
    .DST_BASES(32'h1000_0000), .REGION_SIZES(32'h0001_0000)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .m_cyc_i(cyc), .m_stb_i(stb), .m_we_i(we),
    .m_sel_i(sel), .m_adr_i(adr), .m_dat_i(wdat), .m_cti_i(cti), .m_bte_i(bte),
    .m_ack_o(m_ack[2]), .m_err_o(m_err[2]), .m_dat_o(m_rdat[2]),
    .s_cyc_o(o_cyc[2]), .s_stb_o(o_stb[2]), .s_we_o(o_we[2]), .s_sel_o(o_sel[2]),
    .s_adr_o(o_adr[2]), .s_dat_o(o_dat[2]), .s_cti_o(o_cti[2]), .s_bte_o(o_bte[2]),
    .s_ack_i(s_ack), .s_err_i(s_err), .s_dat_i(s_rdat));

  // u3: both stages off
  wb_addr_remap #(.ORIGIN_EN(1'b0), .N_REGIONS(0), .SRC_BASES('0),
    .DST_BASES('0), .REGION_SIZES('0)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .m_cyc_i(cyc), .m_stb_i(stb), .m_we_i(we),
    .m_sel_i(sel), .m_adr_i(adr), .m_dat_i(wdat), .m_cti_i(cti), .m_bte_i(bte),
    .m_ack_o(m_ack[3]), .m_err_o(m_err[3]), .m_dat_o(m_rdat[3]),
    .s_cyc_o(o_cyc[3]), .s_stb_o(o_stb[3]), .s_we_o(o_we[3]), .s_sel_o(o_sel[3]),
    .s_adr_o(o_adr[3]), .s_dat_o(o_dat[3]), .s_cti_o(o_cti[3]), .s_bte_o(o_bte[3]),
    .s_ack_i(s_ack), .s_err_i(s_err), .s_dat_i(s_rdat));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // change the address mid-cycle, sample a quarter period later
  task automatic put_adr(input logic [31:0] a);
    @(posedge clk);
    #(CLK_PERIOD/4);
    adr = a;
    #(CLK_PERIOD/4);
  endtask

  task automatic t_reset();
    chk("R1 idle cyc", {31'b0, o_cyc[0]}, 32'h0);
    chk("R1 idle stb", {31'b0, o_stb[0]}, 32'h0);
    chk("R2 idle ack", {31'b0, m_ack[0]}, 32'h0);
  endtask

  task automatic t_fwd();
    @(posedge clk); #(CLK_PERIOD/4);
    cyc = 1; stb = 1; we = 1; sel = 4'b1010; wdat = 32'hdead_beef;
    cti = 3'b010; bte = 2'b11; s_ack = 1; s_err = 1; s_rdat = 32'h1234_5678;
    #(CLK_PERIOD/4);
    for (int k = 0; k < 4; k++) begin
      chk("R1 ctl", {24'b0, o_cyc[k], o_stb[k], o_we[k], o_sel[k], 1'b0},
          {24'b0, 3'b111, 4'b1010, 1'b0});
      chk("R1 data", o_dat[k], 32'hdead_beef);
      chk("R1 tags", {27'b0, o_cti[k], o_bte[k]}, {27'b0, 3'b010, 2'b11});
      chk("R2 rsp", {30'b0, m_ack[k], m_err[k]}, 32'h3);
      chk("R2 rdata", m_rdat[k], 32'h1234_5678);
    end
    @(posedge clk); #(CLK_PERIOD/4);
    we = 0; sel = 4'b0101; wdat = 32'h0; s_err = 0; s_rdat = 32'hcafe_0001;
    #(CLK_PERIOD/4);
    chk("R1 we low", {31'b0, o_we[2]}, 32'h0);
    chk("R1 sel", {28'b0, o_sel[2]}, 32'h5);
    chk("R2 err low", {31'b0, m_err[1]}, 32'h0);
    chk("R2 rdata2", m_rdat[3], 32'hcafe_0001);
  endtask

  function automatic logic [31:0] win(input logic [31:0] a);
    return 32'h0001_0000 + (a & 32'h0fff_ffff);
  endfunction

  task automatic t_window();
    logic [31:0] v [5] = '{32'h0, 32'h0000_0004, 32'h1000_0004, 32'h0fff_fffc, 32'hffff_fff0};
    for (int k = 0; k < 5; k++) begin
      put_adr(v[k]);
      chk("R3 window", o_adr[0], win(v[k]));
    end
    put_adr(32'h1000_0004);
    chk("R3 alias", o_adr[0], 32'h0001_0004);
  endtask

  task automatic t_regions();
    put_adr(32'h0001_0004); chk("R4 region1", o_adr[1], 32'h1000_0004);
    put_adr(32'h0002_0008); chk("R4 region2", o_adr[1], 32'h2000_0008);
    put_adr(32'h0003_0fff); chk("R4 top of region3", o_adr[1], 32'h3000_0fff);
    put_adr(32'h0003_0000); chk("R4 base of region3", o_adr[1], 32'h3000_0000);
    put_adr(32'h0000_0000); chk("R5 identity base", o_adr[1], 32'h0000_0000);
    put_adr(32'h0000_0ffc); chk("R5 identity top", o_adr[1], 32'h0000_0ffc);
    put_adr(32'h0000_1000); chk("R7 just past region0", o_adr[1], 32'h0000_1000);
    put_adr(32'h0005_0010); chk("R7 unmatched", o_adr[1], 32'h0005_0010);
    put_adr(32'h0001_0040); chk("R8 lowest index wins", o_adr[1], 32'h1000_0040);
    put_adr(32'h0001_0200); chk("R8 outside overlap", o_adr[1], 32'h1000_0200);
  endtask

  task automatic t_chain();
    put_adr(32'h0000_0000); chk("R6 chain base", o_adr[2], 32'h1000_0000);
    put_adr(32'h0008_1234); chk("R6 chain wrap", o_adr[2], 32'h1000_1234);
    put_adr(32'h0000_fffc); chk("R6 chain top", o_adr[2], 32'h1000_fffc);
    put_adr(32'h0002_0000); chk("R7 chain miss", o_adr[2], 32'h0003_0000);
  endtask

  task automatic t_identity();
    put_adr(32'h8765_4321); chk("R10 off", o_adr[3], 32'h8765_4321);
    put_adr(32'h0001_0004); chk("R10 off2", o_adr[3], 32'h0001_0004);
  endtask

  task automatic t_latency();
    logic [31:0] v [4] = '{32'h0, 32'h4, 32'h8, 32'hc};
    for (int k = 0; k < 4; k++) begin
      put_adr(32'h1000_0000 | v[k]);
      chk("R9 same cycle", o_adr[0], 32'h0001_0000 | v[k]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD/4);
    t_reset();
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b1;
    t_fwd();
    t_window();
    t_regions();
    t_chain();
    t_identity();
    t_latency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule